// File: doc/BRIEF.md
# Transmit Completion Status Sequencer

This block finishes the handling of a transmit packet once software has queued its packet number. Packet numbers go into a short in-order queue. For the packet at the head of that queue, the block first waits a fixed settling time of 10 µs. It then reads the packet's header bytes from the shared packet buffer through a byte-wide port whose reads take one cycle. From those bytes it learns the stored byte count and whether the destination address is the all-ones broadcast address. When the frame has a payload and the link is up, it also reads the trailing control byte, which says whether the frame has an odd or even number of bytes.

After the reads, the block resolves the frame:

- **Link up:** it issues a send request carrying the payload length. When the transmit control word selects loopback, it also issues a loopback request.
- **Link down:** it records lost-carrier and signal-quality errors as the control word selects and asks for transmit enable to be dropped. It raises a PHY-status event, flushes the data FIFOs and withholds the transmit-complete event.

In every case it writes a 16-bit status word back, low byte first, into bytes 0 and 1 of the same buffer.

States and transitions. `S_IDLE` goes to `S_DELAY` when the queue holds a packet. `S_DELAY` goes to `S_HDR_REQ` when the timer expires. `S_HDR_REQ` and `S_HDR_CAP` alternate for eight header bytes, at offsets 2 to 9. After the last header byte, `S_HDR_CAP` goes to `S_CTL_REQ` for a long frame on a live link, and otherwise to `S_RESOLVE`. `S_CTL_REQ` goes to `S_CTL_CAP`, which goes to `S_RESOLVE`. `S_RESOLVE` goes to `S_WB_LO`, then `S_WB_HI`, and `S_WB_HI` returns to `S_IDLE` and pops the queue.

Top module: `tx_status_seq`

## Requirements
- R1: The first buffer read for a packet comes exactly DELAY_US×CLK_MHZ+3 clock edges after the edge that samples its enqueue (with an empty queue and an idle block).
- R2: The status word starts as 0x0001. Bit 6 (0x0040) is added when buffer bytes 4 through 9 all equal 0xFF. A single byte that differs clears the broadcast bit.
- R3: With the link down, a stored length above 4 and transmit-control bit 10 set, status bit 10 (0x0400) is set and `txen_clear` pulses.
- R4: With the link down, a stored length above 4 and transmit-control bit 12 set, status bit 5 (0x0020) is set and `txen_clear` pulses. With neither bit 10 nor bit 12 set, no error bit is set and `txen_clear` stays low.
- R5: With the link down and a stored length above 4, no send occurs. `ev_phy` and `fifo_flush` each pulse once, and `ev_tx_done` does not pulse.
- R6: The stored length is the 11-bit little-endian value in buffer bytes 2 (low) and 3 (bits 2:0). With the link up and a length above 4, the block reads the control byte at offset length−1. If bit 5 of that byte is set, the frame is odd and `send_len` = length−5. Otherwise `send_len` = length−6, floored at 0. `send_pkt` is the packet number.
- R7: `loop_valid` pulses together with the send when any of transmit-control bits 13, 11 or 1 (mask 0x2802) is set, and not otherwise.
- R8: The final status is written to buffer offset 0 (bits 7:0) and then offset 1 (bits 15:8) on consecutive cycles. `ev_tx_done` pulses with the second write unless the link-down path of R5 was taken.
- R9: A frame whose stored length is 4 or less produces no send, no loopback, no link-down actions and no control-byte read, whatever the link state. It still gets the status write and `ev_tx_done`.
- R10: Out of reset the block is idle with `busy` low and status 0. Only one packet is in flight at a time, and queued packets complete in enqueue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue strobe for a transmit packet number |
| enq_pkt | input | PNUM_W | Packet number to enqueue |
| link_up | input | 1 | Link state, 1 = connected |
| tx_ctrl | input | 16 | Transmit control word (bits 0, 1, 10, 11, 12, 13 used) |
| mem_addr | output | PNUM_W+OFF_W | Byte address: {packet, offset} |
| mem_rd | output | 1 | Read strobe; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after `mem_rd` |
| send_valid | output | 1 | One-cycle send request |
| send_pkt | output | PNUM_W | Packet being sent |
| send_len | output | 11 | Payload length starting at offset 4 |
| loop_valid | output | 1 | One-cycle loopback request (with send) |
| txen_clear | output | 1 | Pulse: drop transmit enable |
| fifo_flush | output | 1 | Pulse: flush both data FIFOs |
| ev_phy | output | 1 | Pulse: PHY-status interrupt event |
| ev_tx_done | output | 1 | Pulse: transmit-complete interrupt event |
| status_word | output | 16 | Last resolved status word |
| busy | output | 1 | A packet is being processed |

## Verification
- **Wrong header or broadcast state.** A header byte captured at the wrong offset, or a broadcast flag not reset between packets, shows up as a wrong status word in buffer bytes 0 and 1. It is visible on the write strobes about 20 cycles after the delay ends.
- **Wrong odd/even or length decode.** A bad decode of the control byte or the length appears at once in `send_len` on the send pulse.
- **Wrong link-down flag.** A link-down flag latched wrongly moves the frame between the send path and the `ev_phy`/`fifo_flush` path. It also either suppresses or wrongly emits `ev_tx_done`.
- **Wrong timer or queue state.** A miscounting delay timer shifts the first read away from its exact cycle. A queue pointer error reorders or repeats the packet numbers seen on the status writes.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
    localparam int LEN_W = 11;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DELAY,
        S_HDR_REQ,
        S_HDR_CAP,
        S_CTL_REQ,
        S_CTL_CAP,
        S_RESOLVE,
        S_WB_LO,
        S_WB_HI
    } seq_state_t;

    localparam logic [15:0] ST_BASE    = 16'h0001;
    localparam logic [15:0] ST_BCAST   = 16'h0040;
    localparam logic [15:0] ST_SQE     = 16'h0020;
    localparam logic [15:0] ST_NOCARR  = 16'h0400;

    localparam int          CTL_NOCARR_BIT = 10;
    localparam int          CTL_SQE_BIT    = 12;
    localparam logic [15:0] CTL_LOOP_MASK  = 16'h2802;
    localparam int          ODD_FLAG_BIT   = 5;
endpackage

// File: rtl/tx_pkt_queue.sv
module tx_pkt_queue #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] slot [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (cnt != (PW+1)'(DEPTH));
    assign head    = slot[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                slot[wp] <= din;
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tx_delay_timer.sv
module tx_delay_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/tx_status_seq.sv
module tx_status_seq
    import tx_seq_pkg::*;
#(
    parameter int PNUM_W    = 4,
    parameter int QDEPTH    = 4,
    parameter int BUF_BYTES = 2048,
    parameter int CLK_MHZ   = 100,
    parameter int DELAY_US  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_valid,
    input  logic [PNUM_W-1:0]            enq_pkt,
    input  logic                         link_up,
    input  logic [15:0]                  tx_ctrl,
    output logic [PNUM_W+$clog2(BUF_BYTES)-1:0] mem_addr,
    output logic                         mem_rd,
    output logic                         mem_wr,
    output logic [7:0]                   mem_wdata,
    input  logic [7:0]                   mem_rdata,
    output logic                         send_valid,
    output logic [PNUM_W-1:0]            send_pkt,
    output logic [10:0]                  send_len,
    output logic                         loop_valid,
    output logic                         txen_clear,
    output logic                         fifo_flush,
    output logic                         ev_phy,
    output logic                         ev_tx_done,
    output logic [15:0]                  status_word,
    output logic                         busy
);
    localparam int OFF_W        = $clog2(BUF_BYTES);
    localparam int DELAY_CYCLES = DELAY_US * CLK_MHZ;
    localparam int SW           = $clog2(DELAY_CYCLES + 1);

    seq_state_t state_q, state_d;

    logic [PNUM_W-1:0] q_head, pkt_q;
    logic              q_empty, q_pop, tmr_start, tmr_expired;
    logic [2:0]        idx_q;
    logic [LEN_W-1:0]  len_q, trim;
    logic [7:0]        ctl_byte_q;
    logic              bc_q, fail_q, long_frame;
    logic [15:0]       status_q, status_w;
    logic [OFF_W-1:0]  off;

    tx_pkt_queue #(.W(PNUM_W), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(enq_valid), .din(enq_pkt),
        .pop(q_pop), .head(q_head), .empty(q_empty)
    );

    tx_delay_timer #(.CYCLES(DELAY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .expired(tmr_expired)
    );

    assign long_frame  = (len_q > LEN_W'(4));
    assign trim        = ctl_byte_q[ODD_FLAG_BIT] ? LEN_W'(5) : LEN_W'(6);
    assign send_len    = (len_q > trim) ? (len_q - trim) : '0;
    assign send_pkt    = pkt_q;
    assign mem_addr    = {pkt_q, off};
    assign status_word = status_q;
    assign busy        = (state_q != S_IDLE);

    assign status_w = ST_BASE
                    | (bc_q ? ST_BCAST : 16'h0)
                    | ((fail_q && tx_ctrl[CTL_NOCARR_BIT]) ? ST_NOCARR : 16'h0)
                    | ((fail_q && tx_ctrl[CTL_SQE_BIT])    ? ST_SQE    : 16'h0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        mem_wdata  = 8'h00;
        off        = '0;
        send_valid = 1'b0;
        loop_valid = 1'b0;
        txen_clear = 1'b0;
        fifo_flush = 1'b0;
        ev_phy     = 1'b0;
        ev_tx_done = 1'b0;
        q_pop      = 1'b0;
        tmr_start  = 1'b0;
        unique case (state_q)
            S_IDLE: if (!q_empty) begin
                tmr_start = 1'b1;
                state_d   = S_DELAY;
            end
            S_DELAY: if (tmr_expired) state_d = S_HDR_REQ;
            S_HDR_REQ: begin
                mem_rd  = 1'b1;
                off     = OFF_W'(idx_q) + OFF_W'(2);
                state_d = S_HDR_CAP;
            end
            S_HDR_CAP: begin
                if (idx_q != 3'd7)            state_d = S_HDR_REQ;
                else if (long_frame && link_up) state_d = S_CTL_REQ;
                else                          state_d = S_RESOLVE;
            end
            S_CTL_REQ: begin
                mem_rd  = 1'b1;
                off     = OFF_W'(len_q - LEN_W'(1));
                state_d = S_CTL_CAP;
            end
            S_CTL_CAP: state_d = S_RESOLVE;
            S_RESOLVE: begin
                if (fail_q) begin
                    ev_phy     = 1'b1;
                    fifo_flush = 1'b1;
                    txen_clear = tx_ctrl[CTL_NOCARR_BIT] | tx_ctrl[CTL_SQE_BIT];
                end else if (long_frame) begin
                    send_valid = 1'b1;
                    loop_valid = |(tx_ctrl & CTL_LOOP_MASK);
                end
                state_d = S_WB_LO;
            end
            S_WB_LO: begin
                mem_wr    = 1'b1;
                off       = OFF_W'(0);
                mem_wdata = status_q[7:0];
                state_d   = S_WB_HI;
            end
            S_WB_HI: begin
                mem_wr     = 1'b1;
                off        = OFF_W'(1);
                mem_wdata  = status_q[15:8];
                ev_tx_done = !fail_q;
                q_pop      = 1'b1;
                state_d    = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q      <= '0;
            idx_q      <= '0;
            len_q      <= '0;
            ctl_byte_q <= '0;
            bc_q       <= 1'b1;
            fail_q     <= 1'b0;
            status_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    pkt_q      <= q_head;
                    idx_q      <= '0;
                    bc_q       <= 1'b1;
                    ctl_byte_q <= '0;
                end
                S_HDR_CAP: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == 3'd0)      len_q[7:0]       <= mem_rdata;
                    else if (idx_q == 3'd1) len_q[LEN_W-1:8] <= mem_rdata[LEN_W-9:0];
                    else                    bc_q <= bc_q && (mem_rdata == 8'hFF);
                    if (idx_q == 3'd7) fail_q <= long_frame && !link_up;
                end
                S_CTL_CAP: ctl_byte_q <= mem_rdata;
                S_RESOLVE: status_q   <= status_w;
                default: ;
            endcase
        end
    end

    // cycles spent since leaving idle, for the delay check
    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == S_IDLE) since_q <= '0;
        else if (since_q != SW'(DELAY_CYCLES)) since_q <= since_q + 1'b1;
    end

    p_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (since_q == SW'(DELAY_CYCLES)));
    p_status_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && off == '0) |-> mem_wdata[0]);
    p_clr_needs_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txen_clear |-> ev_phy);
    p_phy_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_phy |-> (fifo_flush && !send_valid));
    p_loop_with_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loop_valid |-> send_valid);
    p_wb_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && off == '0) |=> (mem_wr && off == OFF_W'(1) && $stable(pkt_q)));
    p_done_on_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |-> (mem_wr && off == OFF_W'(1) && !fail_q));
    p_no_rw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

// File: tb/tb_tx_status_seq.sv
module tb_tx_status_seq;
    localparam int PNUM_W = 3;
    localparam int BUFB   = 128;
    localparam int OFF_W  = 7;
    localparam int DELAY  = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_valid = 1'b0;
    logic [PNUM_W-1:0] enq_pkt = '0;
    logic link_up = 1'b1;
    logic [15:0] tx_ctrl = 16'h0001;
    logic [PNUM_W+OFF_W-1:0] mem_addr;
    logic mem_rd, mem_wr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic send_valid, loop_valid, txen_clear, fifo_flush, ev_phy, ev_tx_done, busy;
    logic [PNUM_W-1:0] send_pkt;
    logic [10:0] send_len;
    logic [15:0] status_word;

    always #5 clk = ~clk;

    tx_status_seq #(.PNUM_W(PNUM_W), .QDEPTH(4), .BUF_BYTES(BUFB),
                    .CLK_MHZ(100), .DELAY_US(10)) dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_pkt(enq_pkt),
        .link_up(link_up), .tx_ctrl(tx_ctrl), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .send_valid(send_valid), .send_pkt(send_pkt),
        .send_len(send_len), .loop_valid(loop_valid), .txen_clear(txen_clear),
        .fifo_flush(fifo_flush), .ev_phy(ev_phy), .ev_tx_done(ev_tx_done),
        .status_word(status_word), .busy(busy)
    );

    // packet buffer model, one-cycle read
    logic [7:0] mem [0:(1<<(PNUM_W+OFF_W))-1];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // event monitor
    int cyc = 0, n_send = 0, n_loop = 0, n_phy = 0, n_flush = 0, n_clr = 0;
    int n_done = 0, n_rd = 0, t_enq = 0, t_rd = 0, wr_n = 0;
    logic armed = 1'b0;
    int last_len = 0, last_pkt = 0;
    int wr_log [0:7];
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (send_valid) begin n_send <= n_send + 1; last_len <= send_len; last_pkt <= send_pkt; end
            if (loop_valid) n_loop  <= n_loop + 1;
            if (ev_phy)     n_phy   <= n_phy + 1;
            if (fifo_flush) n_flush <= n_flush + 1;
            if (txen_clear) n_clr   <= n_clr + 1;
            if (ev_tx_done) n_done  <= n_done + 1;
            if (mem_rd)     n_rd    <= n_rd + 1;
            if (enq_valid)  begin t_enq <= cyc; armed <= 1'b1; end
            if (mem_rd && armed) begin t_rd <= cyc; armed <= 1'b0; end
            if (mem_wr && mem_addr[OFF_W-1:0] == '0 && wr_n < 8) begin
                wr_log[wr_n] <= mem_addr[PNUM_W+OFF_W-1:OFF_W];
                wr_n <= wr_n + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [10:0] len;
        logic [7:0]  cbyte;
        logic        bc;
        logic        link;
        logic [15:0] ctl;
        logic [15:0] st;
        logic        snd;
        logic [10:0] slen;
        logic        lp;
        logic        phy;
        logic        clr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{11'd64, 8'h20, 1'b0, 1'b1, 16'h0001, 16'h0001, 1'b1, 11'd59, 1'b0, 1'b0, 1'b0},
        '{11'd64, 8'h00, 1'b1, 1'b1, 16'h0001, 16'h0041, 1'b1, 11'd58, 1'b0, 1'b0, 1'b0},
        '{11'd40, 8'h60, 1'b0, 1'b1, 16'h0002, 16'h0001, 1'b1, 11'd35, 1'b1, 1'b0, 1'b0},
        '{11'd40, 8'h00, 1'b0, 1'b1, 16'h0800, 16'h0001, 1'b1, 11'd34, 1'b1, 1'b0, 1'b0},
        '{11'd40, 8'h00, 1'b0, 1'b1, 16'h2001, 16'h0001, 1'b1, 11'd34, 1'b1, 1'b0, 1'b0},
        '{11'd50, 8'h00, 1'b0, 1'b0, 16'h0401, 16'h0401, 1'b0, 11'd0,  1'b0, 1'b1, 1'b1},
        '{11'd50, 8'h00, 1'b1, 1'b0, 16'h1001, 16'h0061, 1'b0, 11'd0,  1'b0, 1'b1, 1'b1},
        '{11'd50, 8'h00, 1'b0, 1'b0, 16'h1400, 16'h0421, 1'b0, 11'd0,  1'b0, 1'b1, 1'b1},
        '{11'd50, 8'h00, 1'b0, 1'b0, 16'h2803, 16'h0001, 1'b0, 11'd0,  1'b0, 1'b1, 1'b0},
        '{11'd4,  8'h00, 1'b0, 1'b0, 16'h1400, 16'h0001, 1'b0, 11'd0,  1'b0, 1'b0, 1'b0},
        '{11'd3,  8'h00, 1'b1, 1'b1, 16'h2803, 16'h0041, 1'b0, 11'd0,  1'b0, 1'b0, 1'b0},
        '{11'd5,  8'h00, 1'b0, 1'b1, 16'h0001, 16'h0001, 1'b1, 11'd0,  1'b0, 1'b0, 1'b0}
    };

    task automatic load_pkt(input int p, input vec_t v);
        int base;
        base = p * BUFB;
        mem[base]     <= 8'hAA;
        mem[base + 1] <= 8'h55;
        mem[base + 2] <= v.len[7:0];
        mem[base + 3] <= {5'd0, v.len[10:8]};
        for (int k = 4; k < 10; k++)
            mem[base + k] <= (v.bc || k < 9) ? 8'hFF : 8'hFE;
        if (v.len > 4) mem[base + int'(v.len) - 1] <= v.cbyte;
    endtask

    task automatic enqueue(input int p);
        enq_pkt   = PNUM_W'(p);
        enq_valid = 1'b1;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        @(negedge clk);
        while (busy && guard < 20000) begin @(negedge clk); guard++; end
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        int p, base, s_send, s_loop, s_phy, s_flush, s_clr, s_done, s_rd;
        v = TBL[i];
        p = i % 8;
        base = p * BUFB;
        load_pkt(p, v);
        link_up = v.link;
        tx_ctrl = v.ctl;
        @(negedge clk);
        s_send = n_send; s_loop = n_loop; s_phy = n_phy; s_flush = n_flush;
        s_clr = n_clr; s_done = n_done; s_rd = n_rd;
        enqueue(p);
        wait_idle();
        check(t_rd - t_enq == DELAY + 3, "R1 first read delay", t_rd - t_enq, DELAY + 3);
        check({mem[base + 1], mem[base]} == v.st, $sformatf("R2 R3 R4 R8 status vec %0d", i),
              {mem[base + 1], mem[base]}, v.st);
        check(status_word == v.st, "R2 status_word port", status_word, v.st);
        check(n_send - s_send == int'(v.snd), $sformatf("R6 R9 send count vec %0d", i),
              n_send - s_send, v.snd);
        if (v.snd) begin
            check(last_len == int'(v.slen), $sformatf("R6 send_len vec %0d", i), last_len, v.slen);
            check(last_pkt == p, "R6 send_pkt", last_pkt, p);
        end
        check(n_loop - s_loop == int'(v.lp), $sformatf("R7 loopback vec %0d", i),
              n_loop - s_loop, v.lp);
        check(n_phy - s_phy == int'(v.phy), $sformatf("R5 phy event vec %0d", i),
              n_phy - s_phy, v.phy);
        check(n_flush - s_flush == int'(v.phy), $sformatf("R5 flush vec %0d", i),
              n_flush - s_flush, v.phy);
        check(n_clr - s_clr == int'(v.clr), $sformatf("R3 R4 txen_clear vec %0d", i),
              n_clr - s_clr, v.clr);
        check(n_done - s_done == int'(!v.phy), $sformatf("R5 R8 R9 tx done vec %0d", i),
              n_done - s_done, !v.phy);
        // header reads plus the control byte read only on a long frame with a live link
        check(n_rd - s_rd == ((v.len > 4 && v.link) ? 9 : 8), $sformatf("R9 read count vec %0d", i),
              n_rd - s_rd, (v.len > 4 && v.link) ? 9 : 8);
    endtask

    initial begin
        for (int a = 0; a < (1 << (PNUM_W + OFF_W)); a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        // reset state
        check(busy == 1'b0, "R10 busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && status_word == 16'h0, "R10 idle after reset", status_word, 0);
        check(n_rd == 0 && n_send == 0, "R10 no activity after reset", n_rd, 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // queue order with back-to-back enqueues
        link_up = 1'b1;
        tx_ctrl = 16'h0001;
        load_pkt(5, TBL[10]);
        load_pkt(2, TBL[9]);
        load_pkt(6, TBL[10]);
        @(negedge clk);
        wr_n = 0;
        enqueue(5);
        enqueue(2);
        enqueue(6);
        check(busy == 1'b1, "R10 busy during processing", busy, 1);
        wait_idle();
        wait_idle();
        wait_idle();
        check(wr_n == 3, "R10 three completions", wr_n, 3);
        check(wr_log[0] == 5, "R10 order first", wr_log[0], 5);
        check(wr_log[1] == 2, "R10 order second", wr_log[1], 2);
        check(wr_log[2] == 6, "R10 order third", wr_log[2], 6);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule